// File: doc/BRIEF.md
# Issue-Stage Register Scoreboard with Per-Class Result Latency

This block sits in the issue stage of a pipelined integer core that issues wide bundles. It keeps a short countdown per architectural register, one bank for the 64 general registers and one for the 8 one-bit branch registers. From these countdowns it decides each cycle whether the candidate bundle can issue. A bundle presents up to eight general-register reads, one branch-register read and up to four writes. Each write names its target file, its register index and the class of the operation that produces it.

The class sets how long a result takes. An ordinary ALU result can be consumed in the very next cycle. Load, multiply and compare-to-branch results need three cycles. The block raises `stall` when a read would see a result that is not ready (read-after-write). It also raises `stall` when a write would land on a register that still has an older result in flight (write-after-write). Reads against later writes never matter. When the bundle issues, the block loads the countdown of every register it writes.

While a bundle is held, no countdown is loaded, but all countdowns keep running down. A synchronous flush empties the whole scoreboard. General register 0 is hard-wired to zero, so it is never tracked. Register 63 is tracked like any other register.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every countdown is zero, so no bundle of any content stalls until something has issued.
- R2: A read of a general register written by an issued ALU-class operation (class code 0) does not stall in the cycle right after issue.
- R3: A read of a register written by a load (class 1), multiply (class 2) or compare-to-branch (class 3) operation stalls for the two cycles after issue and is free from the third cycle on.
- R4: Writes with `dst_to_br`=1 update the branch-register bank using the low 3 bits of the index, and only `bsrc_idx` is checked against that bank. A general register and a branch register with the same index never interact.
- R5: General register index 0 is never recorded as a destination, and a read of it never stalls.
- R6: A write to a register that an earlier bundle read, or that the same bundle reads, never causes a stall when that register has no pending result.
- R7: A write to a register whose countdown is nonzero stalls. A write one cycle after an ALU-class write to the same register does not stall.
- R8: A stalled bundle records none of its writes, and every countdown still decrements by one in each stalled cycle.
- R9: `flush` high at a clock edge clears every countdown and prevents the bundle of that cycle from being recorded.
- R10: Slots whose valid bit is low are ignored, and `stall` is low whenever `bnd_vld` is low.
- R11: General register 63 is tracked like any other nonzero general register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Synchronous clear of all countdowns |
| bnd_vld | input | 1 | A candidate bundle is present |
| src_vld | input | 8 | Per-slot general source valid |
| src_idx | input | 8x6 | General source register indices |
| bsrc_vld | input | 1 | Branch-register source valid |
| bsrc_idx | input | 3 | Branch-register source index |
| dst_vld | input | 4 | Per-slot destination valid |
| dst_to_br | input | 4 | Destination targets the branch-register bank |
| dst_idx | input | 4x6 | Destination register indices |
| dst_cls | input | 4x2 | Producer class: 0 ALU, 1 load, 2 multiply, 3 compare-to-branch |
| stall | output | 1 | Bundle must be held this cycle |

## Verification
The bench sweeps every producer class against reader distances of one to four cycles, in both the read and the write form. A wrong latency table shows up as an early release or a stall one cycle too long. It walks all 64 general and all 8 branch indices, which catches an r0 that gets tracked, an r63 that is dropped, and branch and general banks that alias one another. It also holds a bundle behind a pending load and then probes the held bundle's destination. A design that records a write during a stall, or that freezes its countdowns while stalled, releases at the wrong cycle. Flush, invalid slots and write-after-read cases are each probed at the first cycle at which a wrong design would stall.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        CLS_ALU   = 2'd0,
        CLS_LOAD  = 2'd1,
        CLS_MUL   = 2'd2,
        CLS_CMPBR = 2'd3
    } op_cls_e;
endpackage

// File: rtl/sb_count_bank.sv
module sb_count_bank #(
    parameter int N   = 64,
    parameter int NLD = 4,
    parameter int CW  = 2,
    parameter int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [NLD-1:0]           ld_en,
    input  logic [NLD-1:0][IW-1:0]   ld_idx,
    input  logic [NLD-1:0][CW-1:0]   ld_val,
    output logic [N-1:0][CW-1:0]     cnt
);
    typedef struct packed {
        logic [N-1:0][CW-1:0] cnt;
    } bank_s;

    bank_s         st_d, st_q;
    logic [N-1:0]  hit;

    always_comb begin
        st_d = st_q;
        hit  = '0;
        for (int i = 0; i < N; i++) begin
            if (st_q.cnt[i] != '0)
                st_d.cnt[i] = st_q.cnt[i] - CW'(1);
            for (int k = 0; k < NLD; k++) begin
                if (ld_en[k] && (ld_idx[k] == IW'(i))) begin
                    hit[i]      = 1'b1;
                    st_d.cnt[i] = ld_val[k];
                end
            end
            if (flush)
                st_d.cnt[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chk
            // R8
            countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!flush && !hit[g] && (cnt[g] != '0)) |=> (cnt[g] == $past(cnt[g]) - CW'(1)));
            // R9
            flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                flush |=> (cnt[g] == '0));
        end
    endgenerate
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
    parameter int NGPR = 64,
    parameter int NBR  = 8,
    parameter int NSRC = 8,
    parameter int NDST = 4,
    parameter int CW   = 2,
    parameter int GIW  = $clog2(NGPR),
    parameter int BIW  = $clog2(NBR)
) (
    input  logic [NGPR-1:0][CW-1:0]  gcnt,
    input  logic [NBR-1:0][CW-1:0]   bcnt,
    input  logic [NSRC-1:0]          src_vld,
    input  logic [NSRC-1:0][GIW-1:0] src_idx,
    input  logic                     bsrc_vld,
    input  logic [BIW-1:0]           bsrc_idx,
    input  logic [NDST-1:0]          dst_vld,
    input  logic [NDST-1:0]          dst_to_br,
    input  logic [NDST-1:0][GIW-1:0] dst_idx,
    output logic                     raw_hit,
    output logic                     waw_hit
);
    always_comb begin
        raw_hit = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_vld[s] && (src_idx[s] != '0) && (gcnt[src_idx[s]] != '0))
                raw_hit = 1'b1;
        end
        if (bsrc_vld && (bcnt[bsrc_idx] != '0))
            raw_hit = 1'b1;
    end

    always_comb begin
        waw_hit = 1'b0;
        for (int k = 0; k < NDST; k++) begin
            if (dst_vld[k]) begin
                if (dst_to_br[k]) begin
                    if (bcnt[dst_idx[k][BIW-1:0]] != '0) waw_hit = 1'b1;
                end else begin
                    if ((dst_idx[k] != '0) && (gcnt[dst_idx[k]] != '0)) waw_hit = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
    parameter int NGPR      = 64,
    parameter int NBR       = 8,
    parameter int NSRC      = 8,
    parameter int NDST      = 4,
    parameter int LAT_ALU   = 1,
    parameter int LAT_LOAD  = 3,
    parameter int LAT_MUL   = 3,
    parameter int LAT_CMPBR = 3,
    parameter int GIW       = $clog2(NGPR),
    parameter int BIW       = $clog2(NBR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     bnd_vld,
    input  logic [NSRC-1:0]          src_vld,
    input  logic [NSRC-1:0][GIW-1:0] src_idx,
    input  logic                     bsrc_vld,
    input  logic [BIW-1:0]           bsrc_idx,
    input  logic [NDST-1:0]          dst_vld,
    input  logic [NDST-1:0]          dst_to_br,
    input  logic [NDST-1:0][GIW-1:0] dst_idx,
    input  logic [NDST-1:0][1:0]     dst_cls,
    output logic                     stall
);
    import sb_pkg::*;

    localparam int LAT_MAX = (LAT_LOAD > LAT_MUL) ?
                             ((LAT_LOAD > LAT_CMPBR) ? LAT_LOAD : LAT_CMPBR) :
                             ((LAT_MUL > LAT_CMPBR) ? LAT_MUL : LAT_CMPBR);
    localparam int CW = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

    logic [NGPR-1:0][CW-1:0]  gcnt;
    logic [NBR-1:0][CW-1:0]   bcnt;
    logic                     raw_hit, waw_hit, issue;
    logic [NDST-1:0]          g_we, b_we;
    logic [NDST-1:0][CW-1:0]  ld_val;
    logic [NDST-1:0][BIW-1:0] b_idx;

    sb_hazard_check #(
        .NGPR(NGPR), .NBR(NBR), .NSRC(NSRC), .NDST(NDST), .CW(CW), .GIW(GIW), .BIW(BIW)
    ) i_haz (
        .gcnt(gcnt), .bcnt(bcnt),
        .src_vld(src_vld), .src_idx(src_idx),
        .bsrc_vld(bsrc_vld), .bsrc_idx(bsrc_idx),
        .dst_vld(dst_vld), .dst_to_br(dst_to_br), .dst_idx(dst_idx),
        .raw_hit(raw_hit), .waw_hit(waw_hit)
    );

    assign stall = bnd_vld && (raw_hit || waw_hit);
    assign issue = bnd_vld && !stall && !flush;

    always_comb begin
        for (int k = 0; k < NDST; k++) begin
            unique case (op_cls_e'(dst_cls[k]))
                CLS_ALU:   ld_val[k] = CW'(LAT_ALU - 1);
                CLS_LOAD:  ld_val[k] = CW'(LAT_LOAD - 1);
                CLS_MUL:   ld_val[k] = CW'(LAT_MUL - 1);
                default:   ld_val[k] = CW'(LAT_CMPBR - 1);
            endcase
            g_we[k]  = issue && dst_vld[k] && !dst_to_br[k] && (dst_idx[k] != '0);
            b_we[k]  = issue && dst_vld[k] && dst_to_br[k];
            b_idx[k] = dst_idx[k][BIW-1:0];
        end
    end

    sb_count_bank #(.N(NGPR), .NLD(NDST), .CW(CW), .IW(GIW)) i_gbank (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ld_en(g_we), .ld_idx(dst_idx), .ld_val(ld_val), .cnt(gcnt)
    );

    sb_count_bank #(.N(NBR), .NLD(NDST), .CW(CW), .IW(BIW)) i_bbank (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ld_en(b_we), .ld_idx(b_idx), .ld_val(ld_val), .cnt(bcnt)
    );

    // R10
    no_idle_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_vld |-> !stall);
    // R5
    r0_untracked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gcnt[0] == '0);
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gcnt[src_idx[0]] <= CW'(LAT_MAX - 1)));
    // R2
    raw_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_vld && src_vld[0] && (src_idx[0] != '0) && (gcnt[src_idx[0]] != '0)) |-> stall);
    // R8
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && dst_vld[0] && !dst_to_br[0] && (dst_idx[0] != '0) && (gcnt[dst_idx[0]] == '0))
        |=> (gcnt[$past(dst_idx[0])] == '0));
endmodule

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush;
    logic            bnd_vld;
    logic [7:0]      src_vld;
    logic [7:0][5:0] src_idx;
    logic            bsrc_vld;
    logic [2:0]      bsrc_idx;
    logic [3:0]      dst_vld;
    logic [3:0]      dst_to_br;
    logic [3:0][5:0] dst_idx;
    logic [3:0][1:0] dst_cls;
    logic            stall;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    issue_scoreboard i_issue_scoreboard (
        .clk(clk), .rst_n(rst_n), .flush(flush), .bnd_vld(bnd_vld),
        .src_vld(src_vld), .src_idx(src_idx), .bsrc_vld(bsrc_vld), .bsrc_idx(bsrc_idx),
        .dst_vld(dst_vld), .dst_to_br(dst_to_br), .dst_idx(dst_idx), .dst_cls(dst_cls),
        .stall(stall)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic int lat(input int c);
        return (c == 0) ? 1 : 3;
    endfunction

    task automatic idle();
        flush = 0; bnd_vld = 0; src_vld = '0; src_idx = '0; bsrc_vld = 0; bsrc_idx = '0;
        dst_vld = '0; dst_to_br = '0; dst_idx = '0; dst_cls = '0;
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input logic exp);
        #1;
        checks = checks + 1;
        if (stall !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: stall=%b expected=%b", req, stall, exp);
        end
    endtask

    task automatic do_flush();
        idle(); flush = 1; cyc(); idle();
    endtask

    task automatic wr(input int slot, input logic br, input int idx, input int c);
        bnd_vld = 1; dst_vld[slot] = 1; dst_to_br[slot] = br;
        dst_idx[slot] = 6'(idx); dst_cls[slot] = 2'(c);
    endtask

    task automatic rd(input int slot, input int idx);
        bnd_vld = 1; src_vld[slot] = 1; src_idx[slot] = 6'(idx);
    endtask

    // Writer, d-1 idle cycles, then reader (mode 0) or rewriter (mode 1).
    task automatic pair(input string req, input logic br, input int idx, input int c,
                        input int d, input int mode);
        logic e;
        do_flush();
        wr(0, br, idx, c); check(req, 1'b0); cyc(); idle();
        for (int i = 1; i < d; i++) cyc();
        if (mode == 0) begin
            if (br) begin bnd_vld = 1; bsrc_vld = 1; bsrc_idx = 3'(idx); end
            else rd(3, idx);
        end else begin
            wr(2, br, idx, 0);
        end
        e = (!br && idx == 0) ? 1'b0 : (d < lat(c));
        check(req, e);
        cyc(); idle();
    endtask

    initial begin
        idle();
        #23 rst_n = 1; #1;
        // R1 reset state: full bundle reads and writes all free
        for (int s = 0; s < 8; s++) rd(s, s + 1);
        bnd_vld = 1; bsrc_vld = 1; bsrc_idx = 3'd5;
        for (int k = 0; k < 4; k++) wr(k, k[0], 10 + k, k);
        check("R1", 1'b0);
        idle(); cyc();

        // R2 R3 R7 class vs distance sweep, read and write forms
        for (int c = 0; c < 4; c++)
            for (int d = 1; d <= 4; d++)
                for (int m = 0; m < 2; m++)
                    pair((m == 0) ? ((c == 0) ? "R2" : "R3") : "R7", 1'b0, 5, c, d, m);

        // R5 R11 all general indices with a load, read next cycle
        for (int r = 0; r < 64; r++)
            pair((r == 0) ? "R5" : ((r == 63) ? "R11" : "R3"), 1'b0, r, 1, 1, 0);

        // R4 all branch registers with compare-to-branch
        for (int b = 0; b < 8; b++) begin
            pair("R4", 1'b1, b, 3, 1, 0);
            pair("R4", 1'b1, b, 3, 3, 0);
        end

        // R4 no aliasing between banks
        do_flush(); wr(0, 1'b1, 3, 3); cyc(); idle();
        rd(0, 3); wr(1, 1'b0, 3, 0); check("R4", 1'b0); cyc(); idle();
        do_flush(); wr(0, 1'b0, 3, 1); cyc(); idle();
        bnd_vld = 1; bsrc_vld = 1; bsrc_idx = 3'd3; wr(1, 1'b1, 3, 0);
        check("R4", 1'b0); cyc(); idle();

        // R5 write to r0 with a load then rewrite
        pair("R5", 1'b0, 0, 1, 1, 1);

        // R6 write-after-read never stalls
        do_flush(); rd(0, 10); check("R6", 1'b0); cyc(); idle();
        wr(0, 1'b0, 10, 1); check("R6", 1'b0); cyc(); idle();
        do_flush(); rd(0, 12); wr(1, 1'b0, 12, 1); check("R6", 1'b0); cyc(); idle();

        // R8 stalled bundle not recorded, countdown keeps running
        do_flush(); wr(0, 1'b0, 20, 1); cyc(); idle();
        rd(0, 20); wr(1, 1'b0, 21, 1); check("R8", 1'b1); cyc(); idle();
        rd(0, 21); check("R8", 1'b0);
        idle(); rd(0, 20); check("R8", 1'b1); cyc(); idle();
        rd(0, 20); check("R8", 1'b0); cyc(); idle();

        // R9 flush clears and blocks recording
        do_flush(); wr(0, 1'b0, 30, 1); wr(1, 1'b1, 6, 3); cyc(); idle();
        flush = 1; wr(0, 1'b0, 31, 2); cyc(); idle();
        rd(0, 30); rd(1, 31); bsrc_vld = 1; bsrc_idx = 3'd6; check("R9", 1'b0); cyc(); idle();

        // R10 invalid slots and idle bundle
        do_flush(); wr(0, 1'b0, 40, 1); cyc(); idle();
        bnd_vld = 1; src_idx[2] = 6'd40; dst_idx[1] = 6'd40; check("R10", 1'b0);
        idle(); src_vld[0] = 1; src_idx[0] = 6'd40; check("R10", 1'b0);
        idle(); rd(0, 40); check("R10", 1'b1);
        idle(); cyc();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule